// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block owns the refresh duty of an asynchronous page-mode DRAM. Straight out of reset it holds the memory bus. It waits out a power-up settling period, then issues a fixed number of warm-up refresh cycles, and only then raises a ready flag for the rest of the system. From then on an interval timer marks each point at which one refresh is owed. The block asks the access controller for the bus and, once granted, drives its own row and column strobe sequence with column strobe before row strobe, so no address is needed.

Refreshes that fall due while the bus is withheld are remembered in a bounded debt counter. They are then paid back-to-back within a single bus ownership. The interval, the power-up wait and every pulse width are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset the block holds `ready_o` low and both strobes high, and drives no strobe edge for at least `PWRUP_CYC` clock cycles.
- R2: After the power-up wait the block performs exactly `INIT_REFRESHES` refresh cycles while owning the bus without a grant (`own_o` high). Then `ready_o` rises and stays high until the next reset. The interval timer does not run while `ready_o` is low.
- R3: Once ready, one refresh falls due every `INTERVAL_CYC` cycles. `request_o` rises a fixed number of cycles after each due point, so when every grant is immediate, consecutive rises are exactly `INTERVAL_CYC` cycles apart.
- R4: In each refresh cycle `cas_n_o` is low for `CSR_CYC` cycles before `ras_n_o` falls. It stays low for exactly `CHR_CYC` cycles of the row-strobe low time and then returns high.
- R5: `ras_n_o` stays low for exactly `RAS_LOW_CYC` cycles per refresh. It is high for at least `PRECHARGE_CYC` cycles before the next fall.
- R6: After ready, strobes move only while `own_o` is high, and `own_o` is high only after `grant_i` was seen with `request_o` high. While `own_o` is low both strobes are high.
- R7: Refreshes that fall due while one is still pending add to the debt. All of them are issued back-to-back within one ownership, one refresh per due point.
- R8: The debt never exceeds `DEBT_MAX`. Further due points while saturated are dropped.
- R9: `request_o` stays high until the debt is zero. It falls only after the last precharge has completed, with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Bus grant from the access controller, held while `request_o` is high |
| request_o | output | 1 | Bus request for refresh |
| own_o | output | 1 | The block is driving the strobes |
| ready_o | output | 1 | Memory initialised and usable |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |

## Verification
The assertions take for granted that the access controller, once it raises `grant_i`, keeps it high for as long as `request_o` stays high. The assertion tying ownership to grant relies on this. The bench raises grant only after it sees a request, after a chosen delay, and drops it on the first sample after the request falls, so it never breaks that contract. The grant delays are chosen so that each burst finishes well before the next due point. This makes the number of refreshes per ownership an exact expected value.

// File: rtl/dram_rf_pkg.sv
// Shared types for the refresh scheduler.
package dram_rf_pkg;

    // Phases of one column-before-row refresh cycle.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_PRE
    } cbr_phase_t;

    // Scheduler top-level states.
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_INIT,
        ST_IDLE,
        ST_REQ,
        ST_RUN
    } sched_state_t;

endpackage

// File: rtl/rf_tick_timer.sv
// Free-running cycle timer: while enabled, it pulses tick every LIMIT cycles.
// Dropping the enable clears the count.
// Assumes LIMIT >= 2.
module rf_tick_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(LIMIT - 1));

    // Count enabled cycles and wrap on the tick.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !en_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/rf_debt_counter.sv
// Saturating count of refreshes owed.
// inc adds one (up to MAX) and dec removes one.
// When both are raised in the same cycle the count is unchanged.
module rf_debt_counter #(
    parameter int unsigned MAX = 8,
    parameter int unsigned DW  = $clog2(MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [DW-1:0] owed_o
);
    logic [DW-1:0] owed_q;

    assign owed_o = owed_q;

    // Update the owed count from due and completion events.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            owed_q <= '0;
        end else begin
            case ({inc_i, dec_i})
                2'b10:   if (owed_q != DW'(MAX)) owed_q <= owed_q + DW'(1);
                2'b01:   if (owed_q != '0)       owed_q <= owed_q - DW'(1);
                default: owed_q <= owed_q;
            endcase
        end
    end
endmodule

// File: rtl/rf_cbr_seq.sv
// Generates one column-before-row refresh strobe sequence per start.
// The sequence is: column strobe low for CSR cycles, then row strobe low for RASW cycles
// (column strobe held low for the first CHR of them), then both high for RP cycles.
// A start during the final precharge cycle chains the next sequence directly.
// Assumes every parameter >= 1 and CHR < RASW.
module rf_cbr_seq
    import dram_rf_pkg::*;
#(
    parameter int unsigned CSR  = 1,
    parameter int unsigned CHR  = 2,
    parameter int unsigned RASW = 10,
    parameter int unsigned RP   = 6
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic start_i,
    output logic idle_o,
    output logic done_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    localparam int unsigned MAXA = (RASW > RP) ? RASW : RP;
    localparam int unsigned MAXC = (MAXA > CSR) ? MAXA : CSR;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    cbr_phase_t    phase_q;
    logic [CW-1:0] cnt_q;

    assign idle_o  = (phase_q == PH_IDLE);
    assign done_o  = (phase_q == PH_PRE) && (cnt_q == CW'(RP - 1));
    assign ras_n_o = (phase_q != PH_ACT);
    assign cas_n_o = !((phase_q == PH_SETUP) ||
                       ((phase_q == PH_ACT) && (cnt_q < CW'(CHR))));

    // Step through the setup, active and precharge phases.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) phase_q <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (cnt_q == CW'(CSR - 1)) begin
                        phase_q <= PH_ACT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_ACT: begin
                    if (cnt_q == CW'(RASW - 1)) begin
                        phase_q <= PH_PRE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    if (cnt_q == CW'(RP - 1)) begin
                        phase_q <= start_i ? PH_SETUP : PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Refresh and start-up scheduler for an asynchronous page-mode DRAM.
// From reset it owns the bus, waits PWRUP_CYC cycles, then runs INIT_REFRESHES
// warm-up refreshes before raising ready_o.
// It then owes one refresh every INTERVAL_CYC cycles. It requests the bus,
// pays all owed refreshes back-to-back once granted, and releases with both strobes high.
// Assumes grant_i is held high while request_o is high.
module dram_refresh_sched
    import dram_rf_pkg::*;
#(
    parameter int unsigned PWRUP_CYC      = 40000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned INTERVAL_CYC   = 3120,
    parameter int unsigned CSR_CYC        = 1,
    parameter int unsigned CHR_CYC        = 2,
    parameter int unsigned RAS_LOW_CYC    = 10,
    parameter int unsigned PRECHARGE_CYC  = 6,
    parameter int unsigned DEBT_MAX       = 8
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic grant_i,
    output logic request_o,
    output logic own_o,
    output logic ready_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);

    sched_state_t  state_q;
    logic          ready_q;
    logic [IW-1:0] dummies_q;
    logic          pw_tick_w;
    logic          iv_tick_w;
    logic [DW-1:0] owed_w;
    logic          seq_idle_w;
    logic          seq_done_w;
    logic          seq_start_w;
    logic          pay_w;
    logic          more_w;
    logic          last_dummy_w;

    rf_tick_timer #(.LIMIT(PWRUP_CYC)) u_pwrup_timer (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (state_q == ST_WAIT),
        .tick_o  (pw_tick_w)
    );

    rf_tick_timer #(.LIMIT(INTERVAL_CYC)) u_interval_timer (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (ready_q),
        .tick_o  (iv_tick_w)
    );

    assign pay_w = seq_done_w && (state_q == ST_RUN);

    rf_debt_counter #(.MAX(DEBT_MAX), .DW(DW)) u_debt (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .inc_i   (iv_tick_w),
        .dec_i   (pay_w),
        .owed_o  (owed_w)
    );

    rf_cbr_seq #(
        .CSR  (CSR_CYC),
        .CHR  (CHR_CYC),
        .RASW (RAS_LOW_CYC),
        .RP   (PRECHARGE_CYC)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .start_i (seq_start_w),
        .idle_o  (seq_idle_w),
        .done_o  (seq_done_w),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o)
    );

    assign last_dummy_w = (dummies_q == IW'(INIT_REFRESHES - 1));
    assign more_w       = (owed_w > DW'(1)) || iv_tick_w;

    // Decide when the strobe sequencer starts (or chains) a refresh.
    always_comb begin
        case (state_q)
            ST_INIT: seq_start_w = seq_idle_w || (seq_done_w && !last_dummy_w);
            ST_RUN:  seq_start_w = seq_idle_w || (seq_done_w && more_w);
            default: seq_start_w = 1'b0;
        endcase
    end

    // Top-level sequencing: power-up wait, warm-up, then request and pay-back.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q   <= ST_WAIT;
            ready_q   <= 1'b0;
            dummies_q <= '0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (pw_tick_w) state_q <= ST_INIT;
                end
                ST_INIT: begin
                    if (seq_done_w) begin
                        dummies_q <= dummies_q + IW'(1);
                        if (last_dummy_w) begin
                            state_q <= ST_IDLE;
                            ready_q <= 1'b1;
                        end
                    end
                end
                ST_IDLE: begin
                    if (owed_w != '0) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (grant_i) state_q <= ST_RUN;
                end
                default: begin
                    if (seq_done_w && !more_w) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign request_o = (state_q == ST_REQ) || (state_q == ST_RUN);
    assign own_o     = !ready_q || (state_q == ST_RUN);
    assign ready_o   = ready_q;

endmodule

// File: rtl/rf_sched_checker.sv
// Protocol checks for the refresh scheduler, bound to its top.
// Assumes grant_i stays high while request_o is high.
module rf_sched_checker #(
    parameter int unsigned DEBT_MAX = 8,
    parameter int unsigned DW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant,
    input logic          request,
    input logic          own,
    input logic          ready,
    input logic          ras_n,
    input logic          cas_n,
    input logic [DW-1:0] owed
);
    // Column strobe already low the cycle before, and at, the row strobe fall.
    p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // Strobes are parked high whenever the bus is not owned.
    p_park_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !own |-> (ras_n && cas_n));

    // After ready, ownership implies a grant.
    p_own_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && own) |-> grant);

    // Ready never drops without a reset.
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // Debt never passes its bound.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= DW'(DEBT_MAX));

    // Bus released only with both strobes high.
    p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(request) |-> (ras_n && cas_n));
endmodule

bind dram_refresh_sched rf_sched_checker #(.DEBT_MAX(DEBT_MAX), .DW(DW)) u_rf_chk (
    .clk     (clk_i),
    .rst_n   (rst_n_i),
    .grant   (grant_i),
    .request (request_o),
    .own     (own_o),
    .ready   (ready_o),
    .ras_n   (ras_n_o),
    .cas_n   (cas_n_o),
    .owed    (owed_w)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int PW   = 20;
    localparam int NI   = 8;
    localparam int IV   = 100;
    localparam int CSR  = 1;
    localparam int CHR  = 2;
    localparam int RASW = 5;
    localparam int RP   = 3;
    localparam int DMAX = 8;

    localparam int NV = 5;
    // Stimulus: grant delay after request; expected refreshes in that ownership.
    localparam int DLY [NV] = '{0, 0, 5, 150, 250};
    localparam int EXP [NV] = '{1, 1, 1, 2, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic request, own, ready, ras_n, cas_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .PWRUP_CYC(PW), .INIT_REFRESHES(NI), .INTERVAL_CYC(IV), .CSR_CYC(CSR),
        .CHR_CYC(CHR), .RAS_LOW_CYC(RASW), .PRECHARGE_CYC(RP), .DEBT_MAX(DMAX)
    ) i_dram_refresh_sched (
        .clk_i(clk), .rst_n_i(rst_n), .grant_i(grant), .request_o(request),
        .own_o(own), .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n)
    );

    // Monitor state
    int cyc = 0, first_cas = -1, init_falls = 0, burst_falls = 0;
    int low_run = 0, cas_in_low = 0, high_run = 100;
    int last_rise = 0, prev_rise = 0;
    int order_err = 0, pre_err = 0, grant_err = 0, width_err = 0, chr_err = 0, own_err = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_req = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Watch the strobes each cycle for protocol breaks.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; first_cas = -1; init_falls = 0; low_run = 0; cas_in_low = 0;
            high_run = 100; prev_ras = 1'b1; prev_cas = 1'b1; prev_req = 1'b0;
        end else begin
            cyc++;
            if (!prev_req && request) begin
                prev_rise = last_rise; last_rise = cyc; burst_falls = 0;
            end
            if (prev_cas && !cas_n && first_cas < 0) first_cas = cyc;
            if (prev_ras && !ras_n) begin
                if (prev_cas) order_err++;
                if (high_run < RP) pre_err++;
                if (ready && !grant) grant_err++;
                if (!ready) init_falls++;
                if (request) burst_falls++;
                low_run = 0; cas_in_low = 0;
            end
            if (!ras_n) begin
                low_run++;
                if (!cas_n) cas_in_low++;
                high_run = 0;
            end else begin
                if (!prev_ras) begin
                    if (low_run != RASW) width_err++;
                    if (cas_in_low != CHR) chr_err++;
                end
                high_run++;
            end
            if (!own && (!ras_n || !cas_n)) own_err++;
            if (!ready && !own) own_err++;
            prev_ras = ras_n; prev_cas = cas_n; prev_req = request;
        end
    end

    task automatic burst(input int dly, input int exp, input string tag);
        while (!request) step();
        repeat (dly) step();
        grant = 1'b1;
        while (request) step();
        grant = 1'b0;
        chk(burst_falls == exp, tag, burst_falls, exp);
        chk(ras_n && cas_n, "R9 strobes high at release", {ras_n, cas_n}, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk(!ready && ras_n && cas_n && !request, "R1 reset state",
            {ready, ras_n, cas_n, request}, 6);
        rst_n = 1'b1;
        while (!ready) step();
        chk(first_cas >= PW, "R1 power-up wait", first_cas, PW);
        chk(init_falls == NI, "R2 warm-up count", init_falls, NI);
        chk(own_err == 0, "R2 bus owned during warm-up", own_err, 0);

        for (int i = 0; i < NV; i++) begin
            burst(DLY[i], EXP[i], (EXP[i] > 1) ? "R7 debt payback" : "R3 single refresh");
            if (i == 1) chk(last_rise - prev_rise == IV, "R3 interval spacing",
                            last_rise - prev_rise, IV);
        end

        // R8 saturation: withhold grant across many due points
        burst(1000, DMAX, "R8 debt saturates");

        // R1 reset mid-operation
        rst_n = 1'b0;
        repeat (2) step();
        chk(!ready && ras_n && cas_n && !request, "R1 reset again",
            {ready, ras_n, cas_n, request}, 6);
        rst_n = 1'b1;
        while (!ready) step();
        chk(init_falls == NI, "R2 warm-up after reset", init_falls, NI);
        burst(0, 1, "R3 refresh after re-init");

        chk(order_err == 0, "R4 column before row", order_err, 0);
        chk(chr_err == 0, "R4 column hold", chr_err, 0);
        chk(width_err == 0, "R5 row low width", width_err, 0);
        chk(pre_err == 0, "R5 precharge", pre_err, 0);
        chk(grant_err == 0, "R6 strobes only when granted", grant_err, 0);
        chk(own_err == 0, "R6 parked when not owned", own_err, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule